// File: doc/BRIEF.md
# Compare and Flag Unit

This block evaluates relational compare operations on two operands and keeps the single condition flag that a processor's status word carries. On each strobed operation a compare opcode selects one of ten relations (equality, inequality, and four orderings each in signed and unsigned form). The outcome is written into a persistent flag register on the next rising clock edge. Two further opcodes let an arithmetic datapath report whether its add or bitwise-and result was zero. When the arithmetic-flag option is built in, that zero test also writes the flag.

The flag also steers a conditional-move selector. Its result output presents operand A while the flag is set and operand B while it is clear. That lets a pipeline pick between two register values with no branch. Opcodes outside the defined set, and cycles without the valid strobe, leave the flag untouched.

Top module: `cmpflag_unit`

## Requirements
- R1: While rst_n is low the flag reads 0, and it is still 0 after reset is released until an operation writes it.
- R2: Opcode 1 (equal) sets the flag to 1 exactly when opnd_a equals opnd_b. Opcode 2 (not equal) sets it exactly when they differ.
- R3: Signed orderings treat both operands as two's complement. Opcode 3 is a>b, 4 is a>=b, 5 is a<b and 6 is a<=b.
- R4: Unsigned orderings treat both operands as plain magnitudes. Opcode 7 is a>b, 8 is a>=b, 9 is a<b and 10 is a<=b.
- R5: A flag write happens on the rising edge at which op_valid is sampled high, and the new value is visible right after that edge.
- R6: With op_valid low the flag keeps its value, whatever the opcode and operands are.
- R7: With ARITH_FLAG_EN=1, opcode 11 (add result) and opcode 12 (and result) set the flag to 1 exactly when arith_res is all zeros, and to 0 otherwise.
- R8: Opcodes 0, 13, 14 and 15 leave the flag unchanged even when op_valid is high.
- R9: cmov_res equals opnd_a while the flag is 1 and opnd_b while the flag is 0. It follows the current flag and operands without a clock delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Operation strobe |
| op_code | input | 4 | Operation select (encodings in R2, R3, R4, R7, R8) |
| opnd_a | input | DATA_W | First operand |
| opnd_b | input | DATA_W | Second operand |
| arith_res | input | DATA_W | Result of an add or and, used for the zero test |
| flag | output | 1 | Condition flag |
| cmov_res | output | DATA_W | Conditional-move result |

## Verification
The hardest cases to reach are the signed and unsigned orderings at the wrap points. Where a sign bit differs, the two kinds of compare must give opposite answers, and random operands almost never land there. The stimulus therefore crosses every ordered pair drawn from 0, 1, -1, 0x7FFFFFFF and 0x80000000 with all ten compares. Before each ignored opcode and before each cycle without the strobe, the flag is set to a known value of both polarities. That way a stray write is always visible, either on the flag or through the conditional-move output.

// File: rtl/cmpflag_pkg.sv
package cmpflag_pkg;
   localparam int OP_W = 4;

   typedef enum logic [OP_W-1:0] {
      OPC_NONE = 4'd0,
      OPC_EQ   = 4'd1,
      OPC_NE   = 4'd2,
      OPC_GTS  = 4'd3,
      OPC_GES  = 4'd4,
      OPC_LTS  = 4'd5,
      OPC_LES  = 4'd6,
      OPC_GTU  = 4'd7,
      OPC_GEU  = 4'd8,
      OPC_LTU  = 4'd9,
      OPC_LEU  = 4'd10,
      OPC_ADDZ = 4'd11,
      OPC_ANDZ = 4'd12
   } cmp_op_e;

   typedef struct packed {
      logic eq;
      logic lt_s;
      logic lt_u;
   } rel_t;
endpackage

// File: rtl/cmpflag_relcmp.sv
module cmpflag_relcmp
   import cmpflag_pkg::*;
#(
   parameter int W       = 32,
   parameter bit SUB_CMP = 1
) (
   input  logic [OP_W-1:0] op_code,
   input  logic [W-1:0]    opnd_a,
   input  logic [W-1:0]    opnd_b,
   output logic            is_cmp,
   output logic            cmp_val
);
   localparam int MSB = W - 1;

   rel_t rel;

   generate
      if (SUB_CMP) begin : g_sub
         logic [W:0] diff;
         always_comb begin
            diff     = {1'b0, opnd_a} - {1'b0, opnd_b};
            rel.eq   = (diff[MSB:0] == '0);
            rel.lt_u = diff[W];
            rel.lt_s = (opnd_a[MSB] != opnd_b[MSB]) ? opnd_a[MSB] : diff[W];
         end
      end else begin : g_direct
         always_comb begin
            rel.eq   = (opnd_a == opnd_b);
            rel.lt_u = (opnd_a < opnd_b);
            rel.lt_s = ($signed(opnd_a) < $signed(opnd_b));
         end
      end
   endgenerate

   always_comb begin
      is_cmp  = 1'b1;
      cmp_val = 1'b0;
      case (op_code)
         OPC_EQ:  cmp_val = rel.eq;
         OPC_NE:  cmp_val = ~rel.eq;
         OPC_GTS: cmp_val = ~rel.lt_s & ~rel.eq;
         OPC_GES: cmp_val = ~rel.lt_s;
         OPC_LTS: cmp_val = rel.lt_s;
         OPC_LES: cmp_val = rel.lt_s | rel.eq;
         OPC_GTU: cmp_val = ~rel.lt_u & ~rel.eq;
         OPC_GEU: cmp_val = ~rel.lt_u;
         OPC_LTU: cmp_val = rel.lt_u;
         OPC_LEU: cmp_val = rel.lt_u | rel.eq;
         default: is_cmp  = 1'b0;
      endcase
   end
endmodule

// File: rtl/cmpflag_zdet.sv
module cmpflag_zdet
   import cmpflag_pkg::*;
#(
   parameter int W      = 32,
   parameter bit ENABLE = 1
) (
   input  logic [OP_W-1:0] op_code,
   input  logic [W-1:0]    arith_res,
   output logic            is_zop,
   output logic            zero_val
);
   generate
      if (ENABLE) begin : g_on
         always_comb begin
            is_zop   = (op_code == OPC_ADDZ) || (op_code == OPC_ANDZ);
            zero_val = ~|arith_res;
         end
      end else begin : g_off
         assign is_zop   = 1'b0;
         assign zero_val = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/cmpflag_flagreg.sv
module cmpflag_flagreg (
   input  logic clk,
   input  logic rst_n,
   input  logic wr_en,
   input  logic wr_val,
   output logic flag_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     flag_q <= 1'b0;
      else if (wr_en) flag_q <= wr_val;
   end
endmodule

// File: rtl/cmpflag_unit.sv
module cmpflag_unit
   import cmpflag_pkg::*;
#(
   parameter int DATA_W        = 32,
   parameter bit ARITH_FLAG_EN = 1,
   parameter bit SUB_CMP       = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              op_valid,
   input  logic [3:0]        op_code,
   input  logic [DATA_W-1:0] opnd_a,
   input  logic [DATA_W-1:0] opnd_b,
   input  logic [DATA_W-1:0] arith_res,
   output logic              flag,
   output logic [DATA_W-1:0] cmov_res
);
   generate
      if (DATA_W < 2) begin : g_bad_width
         $error("cmpflag_unit: DATA_W must be at least 2");
      end
   endgenerate

   logic is_cmp, cmp_val, is_zop, zero_val;
   logic wr_en, wr_val;

   cmpflag_relcmp #(.W(DATA_W), .SUB_CMP(SUB_CMP)) u_rel (
      .op_code (op_code),
      .opnd_a  (opnd_a),
      .opnd_b  (opnd_b),
      .is_cmp  (is_cmp),
      .cmp_val (cmp_val)
   );

   cmpflag_zdet #(.W(DATA_W), .ENABLE(ARITH_FLAG_EN)) u_zd (
      .op_code   (op_code),
      .arith_res (arith_res),
      .is_zop    (is_zop),
      .zero_val  (zero_val)
   );

   always_comb begin
      wr_en  = op_valid & (is_cmp | is_zop);
      wr_val = is_cmp ? cmp_val : zero_val;
   end

   cmpflag_flagreg u_fr (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (wr_en),
      .wr_val (wr_val),
      .flag_q (flag)
   );

   assign cmov_res = flag ? opnd_a : opnd_b;
endmodule

// File: rtl/cmpflag_chk.sv
module cmpflag_chk #(
   parameter int W     = 32,
   parameter bit ARITH = 1
) (
   input logic         clk,
   input logic         rst_n,
   input logic         op_valid,
   input logic [3:0]   op_code,
   input logic [W-1:0] opnd_a,
   input logic [W-1:0] opnd_b,
   input logic [W-1:0] arith_res,
   input logic         flag,
   input logic [W-1:0] cmov_res
);
   p_reset_low_r1: assert property (@(posedge clk) !rst_n |-> !flag);

   p_eq_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_code == 4'd1) |=> (flag == ($past(opnd_a) == $past(opnd_b))));

   p_lts_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_code == 4'd5) |=> (flag == ($signed($past(opnd_a)) < $signed($past(opnd_b)))));

   p_ltu_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_code == 4'd9) |=> (flag == ($past(opnd_a) < $past(opnd_b))));

   p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !op_valid |=> $stable(flag));

   p_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (ARITH && op_valid && (op_code == 4'd11 || op_code == 4'd12))
      |=> (flag == ($past(arith_res) == '0)));

   p_undef_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && (op_code == 4'd0 || op_code >= 4'd13)) |=> $stable(flag));

   p_cmov_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (flag && opnd_a != opnd_b) |-> (cmov_res != opnd_b));
endmodule

bind cmpflag_unit cmpflag_chk #(.W(DATA_W), .ARITH(ARITH_FLAG_EN)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .op_valid  (op_valid),
   .op_code   (op_code),
   .opnd_a    (opnd_a),
   .opnd_b    (opnd_b),
   .arith_res (arith_res),
   .flag      (flag),
   .cmov_res  (cmov_res)
);

// File: tb/cmpflag_unit_tb.sv
module cmpflag_unit_tb;
   localparam int CLK_PERIOD = 10;
   localparam int W = 32;
   localparam int WDOG = 20000;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         op_valid = 1'b0;
   logic [3:0]   op_code = 4'd0;
   logic [W-1:0] opnd_a = '0;
   logic [W-1:0] opnd_b = '0;
   logic [W-1:0] arith_res = '0;
   logic         flag;
   logic [W-1:0] cmov_res;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   cmpflag_unit u_dut (
      .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
      .opnd_a(opnd_a), .opnd_b(opnd_b), .arith_res(arith_res),
      .flag(flag), .cmov_res(cmov_res)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   function automatic logic ref_cmp(input logic [3:0] op, input logic [W-1:0] a,
                                    input logic [W-1:0] b);
      case (op)
         4'd1:  return a == b;
         4'd2:  return a != b;
         4'd3:  return $signed(a) >  $signed(b);
         4'd4:  return $signed(a) >= $signed(b);
         4'd5:  return $signed(a) <  $signed(b);
         4'd6:  return $signed(a) <= $signed(b);
         4'd7:  return a >  b;
         4'd8:  return a >= b;
         4'd9:  return a <  b;
         default: return a <= b;
      endcase
   endfunction

   task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   // one strobed operation; returns at the negedge after the capturing edge
   task automatic do_op(input logic [3:0] op, input logic [W-1:0] a,
                        input logic [W-1:0] b, input logic [W-1:0] ar);
      op_code = op; opnd_a = a; opnd_b = b; arith_res = ar; op_valid = 1'b1;
      @(negedge clk);
      op_valid = 1'b0;
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      chk("R1 flag in reset", {31'd0, flag}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 flag after reset", {31'd0, flag}, 32'd0);
   endtask

   task automatic t_sweep();
      logic [W-1:0] vals [5];
      vals[0] = 32'h0000_0000; vals[1] = 32'h0000_0001; vals[2] = 32'hFFFF_FFFF;
      vals[3] = 32'h7FFF_FFFF; vals[4] = 32'h8000_0000;
      for (int op = 1; op <= 10; op++)
         for (int i = 0; i < 5; i++)
            for (int j = 0; j < 5; j++) begin
               do_op(op[3:0], vals[i], vals[j], 32'd1);
               if (op <= 2)
                  chk("R2 eq/ne", {31'd0, flag}, {31'd0, ref_cmp(op[3:0], vals[i], vals[j])});
               else if (op <= 6)
                  chk("R3 signed", {31'd0, flag}, {31'd0, ref_cmp(op[3:0], vals[i], vals[j])});
               else
                  chk("R4 unsigned", {31'd0, flag}, {31'd0, ref_cmp(op[3:0], vals[i], vals[j])});
            end
   endtask

   task automatic t_timing();
      do_op(4'd2, 32'd5, 32'd5, '0);          // flag -> 0
      op_code = 4'd1; opnd_a = 32'd9; opnd_b = 32'd9; op_valid = 1'b1;
      @(posedge clk); #1;
      chk("R5 visible after capture edge", {31'd0, flag}, 32'd1);
      @(negedge clk);
      op_valid = 1'b0;
   endtask

   task automatic t_hold();
      do_op(4'd1, 32'd3, 32'd3, '0);          // flag -> 1
      op_code = 4'd2; opnd_a = 32'd3; opnd_b = 32'd3;
      repeat (3) @(negedge clk);
      chk("R6 hold high", {31'd0, flag}, 32'd1);
      do_op(4'd2, 32'd3, 32'd3, '0);          // flag -> 0
      op_code = 4'd1;
      repeat (3) @(negedge clk);
      chk("R6 hold low", {31'd0, flag}, 32'd0);
   endtask

   task automatic t_zero();
      do_op(4'd11, 32'd1, 32'd2, 32'd0);
      chk("R7 add zero", {31'd0, flag}, 32'd1);
      do_op(4'd11, 32'd1, 32'd2, 32'h8000_0000);
      chk("R7 add nonzero", {31'd0, flag}, 32'd0);
      do_op(4'd12, 32'd1, 32'd2, 32'd0);
      chk("R7 and zero", {31'd0, flag}, 32'd1);
      do_op(4'd12, 32'd1, 32'd2, 32'h0000_0001);
      chk("R7 and nonzero", {31'd0, flag}, 32'd0);
   endtask

   task automatic t_ignore();
      logic [3:0] ops [4];
      ops[0] = 4'd0; ops[1] = 4'd13; ops[2] = 4'd14; ops[3] = 4'd15;
      for (int k = 0; k < 4; k++) begin
         do_op(4'd1, 32'd7, 32'd7, '0);       // flag -> 1
         do_op(ops[k], 32'd1, 32'd2, 32'd0);
         chk("R8 ignored opcode keeps 1", {31'd0, flag}, 32'd1);
         do_op(4'd2, 32'd7, 32'd7, '0);       // flag -> 0
         do_op(ops[k], 32'd1, 32'd1, 32'd0);
         chk("R8 ignored opcode keeps 0", {31'd0, flag}, 32'd0);
      end
   endtask

   task automatic t_cmov();
      do_op(4'd1, 32'd4, 32'd4, '0);          // flag -> 1
      opnd_a = 32'hAAAA_5555; opnd_b = 32'h1234_5678; #1;
      chk("R9 cmov flag=1", cmov_res, 32'hAAAA_5555);
      do_op(4'd9, 32'd8, 32'd4, '0);          // flag -> 0
      opnd_a = 32'hAAAA_5555; opnd_b = 32'h1234_5678; #1;
      chk("R9 cmov flag=0", cmov_res, 32'h1234_5678);
      opnd_b = 32'hDEAD_BEEF; #1;
      chk("R9 cmov follows operand", cmov_res, 32'hDEAD_BEEF);
      @(negedge clk);
   endtask

   initial begin
      for (int c = 0; c < WDOG; c++) begin
         @(posedge clk);
         if (done) break;
      end
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      @(negedge clk);
      t_reset();
      t_sweep();
      t_timing();
      t_hold();
      t_zero();
      t_ignore();
      t_cmov();
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule